// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block paces the serial clock of an I2C controller that acts as bus master. From a 16-bit baud count and a two-bit speed selector it produces the interval at which SCL is pulled low and then released. It marks each falling and each rising edge with a one-cycle tick. It also issues a strobe that tells the byte sequencer when SDA may be changed. The line is open drain, so the block only asks for SCL to be pulled low. It watches the sampled bus level to detect a target that is holding the clock low.

One baud interval is the programmed count in module clock cycles, and a count of zero acts as one. In standard mode the low and high phases each last one interval, which gives a period of twice the count. In fast and fast-plus modes the low phase lasts two intervals and the high phase one, which gives three times the count. High-speed mode is not supported and falls back to standard timing. The upper half of the 32-bit baud word carries the high-speed count, and it has no effect here.

A target may stretch the clock after the master releases it. While SCL is seen low, the high-phase count pauses. In the low phase that follows a stretch, the SDA strobe is delayed by a programmable setup count, so data keeps its setup time after the stretch ends.

Top module: `i2c_scl_timer`

## Requirements
- R1: While synchronous reset is low, and on the first cycle after it, scl_pull_low, scl_fall, scl_rise and sda_strobe are all 0.
- R2: When en is low at a clock edge, the block is idle from the next cycle: SCL is released and no tick or strobe is produced.
- R3: On the first edge with en high while idle, the block enters the low phase: scl_pull_low goes to 1 and scl_fall pulses for that one cycle.
- R4: With speed code 0 (standard), the low phase lasts exactly one baud interval of U cycles, where U is baud_word[15:0].
- R5: With speed code 1 (fast) or 2 (fast-plus), the low phase lasts exactly 2*U cycles.
- R6: Speed code 3 (high-speed) is not supported and gives the same timing as code 0.
- R7: At the end of each low phase SCL is released, scl_rise pulses for the first released cycle, and the high phase ends after U edges at which scl_in was sampled high.
- R8: During the high phase, each edge at which scl_in is sampled low does not advance the high-phase count, and the block stays released.
- R9: A baud count of 0 in baud_word[15:0] behaves exactly like a count of 1.
- R10: baud_word[31:16] has no effect on any output.
- R11: sda_strobe pulses exactly once in each low phase. It comes in the first low cycle when the preceding high phase was not stretched. When that high phase was stretched, it comes setup_cyc cycles after the fall, clamped to the last cycle of the low phase.
- R12: scl_fall and scl_rise are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run the clock generator; low returns to idle |
| baud_word | input | 32 | [15:0] baud count in cycles; [31:16] high-speed count, unused |
| speed | input | 2 | 0 standard, 1 fast, 2 fast-plus, 3 high-speed |
| setup_cyc | input | 8 | Data setup delay after a stretch, in cycles |
| scl_in | input | 1 | Sampled SCL bus level, already synchronous to clk |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release |
| scl_fall | output | 1 | Tick in the first cycle of each low phase |
| scl_rise | output | 1 | Tick in the first cycle of each high phase |
| sda_strobe | output | 1 | SDA may change in this cycle |

## Verification
The properties assume that scl_in already comes from a synchroniser and that it can be low only while the block releases the line or while a target holds it. They also assume that baud_word, speed and setup_cyc change only while en is low. The bench follows both rules. It forms scl_in as the wired-AND of the block's own pull and a modelled target hold, and it changes the configuration only between runs with en low. Stretch lengths, setup counts beyond the low-phase length, zero baud and non-zero upper baud bits are each covered by their own run.

// File: rtl/i2c_tmr_pkg.sv
// Shared types and codes for the SCL phase timer.
package i2c_tmr_pkg;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

    // Speed selector codes.
    localparam logic [1:0] SPD_STD   = 2'd0;
    localparam logic [1:0] SPD_FAST  = 2'd1;
    localparam logic [1:0] SPD_FPLUS = 2'd2;
    localparam logic [1:0] SPD_HS    = 2'd3;

    // True when the speed code uses a two-interval low phase.
    function automatic logic is_long_low(input logic [1:0] spd);
        return (spd == SPD_FAST) || (spd == SPD_FPLUS);
    endfunction

endpackage

// File: rtl/i2c_tmr_rate.sv
// Derives the baud interval and the low-phase length from the
// programmed count and speed code. Assumes inputs stable while running.
module i2c_tmr_rate #(
    parameter int BAUD_W    = 16,
    parameter int LONG_MULT = 2
) (
    input  logic [BAUD_W-1:0] baud,
    input  logic [1:0]        speed,
    output logic [BAUD_W-1:0] unit,
    output logic [BAUD_W:0]   low_len
);
    import i2c_tmr_pkg::*;

    localparam int CNT_W = BAUD_W + 1;

    // Clamp a zero count to one cycle.
    always_comb begin
        unit = (baud == '0) ? BAUD_W'(1) : baud;
    end

    // Pick the low-phase length for the selected mode.
    generate
        if (LONG_MULT == 2) begin : g_shift
            always_comb begin
                low_len = is_long_low(speed) ? {unit, 1'b0} : {1'b0, unit};
            end
        end else begin : g_mult
            always_comb begin
                low_len = is_long_low(speed) ? CNT_W'(unit * LONG_MULT) : CNT_W'(unit);
            end
        end
    endgenerate

endmodule

// File: rtl/i2c_tmr_seq.sv
// Phase sequencer: walks idle -> low -> high -> low, counts each phase,
// pauses the high count while the bus is held low and records the stretch.
// Assumes scl_in is already synchronous to clk.
module i2c_tmr_seq #(
    parameter int BAUD_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 scl_in,
    input  logic [BAUD_W-1:0]    unit,
    input  logic [BAUD_W:0]      low_len,
    output i2c_tmr_pkg::phase_t  ph,
    output logic [BAUD_W:0]      low_pos,
    output logic                 stretched,
    output logic                 rise_p,
    output logic                 fall_p
);
    import i2c_tmr_pkg::*;

    logic [BAUD_W-1:0] hi_cnt;
    logic              low_done;
    logic              high_done;

    // End-of-phase detection.
    always_comb begin
        low_done  = (low_pos == low_len - 1'b1);
        high_done = (hi_cnt == unit - 1'b1);
    end

    // Phase state, counters, stretch flag and edge ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            low_pos   <= '0;
            hi_cnt    <= '0;
            stretched <= 1'b0;
            rise_p    <= 1'b0;
            fall_p    <= 1'b0;
        end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (!en) begin
                ph        <= PH_IDLE;
                low_pos   <= '0;
                hi_cnt    <= '0;
                stretched <= 1'b0;
            end else begin
                case (ph)
                    PH_IDLE: begin
                        ph        <= PH_LOW;
                        low_pos   <= '0;
                        stretched <= 1'b0;
                        fall_p    <= 1'b1;
                    end
                    PH_LOW: begin
                        if (low_done) begin
                            ph        <= PH_HIGH;
                            hi_cnt    <= '0;
                            stretched <= 1'b0;
                            rise_p    <= 1'b1;
                        end else begin
                            low_pos <= low_pos + 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (!scl_in) begin
                            stretched <= 1'b1;
                        end else if (high_done) begin
                            ph      <= PH_LOW;
                            low_pos <= '0;
                            fall_p  <= 1'b1;
                        end else begin
                            hi_cnt <= hi_cnt + 1'b1;
                        end
                    end
                    default: ph <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tmr_setup.sv
// SDA change strobe: one pulse per low phase, delayed by the setup count
// when the previous high phase was stretched, clamped to the phase end.
module i2c_tmr_setup #(
    parameter int BAUD_W  = 16,
    parameter int SETUP_W = 8
) (
    input  i2c_tmr_pkg::phase_t ph,
    input  logic [BAUD_W:0]     low_pos,
    input  logic [BAUD_W:0]     low_len,
    input  logic                stretched,
    input  logic [SETUP_W-1:0]  setup_cyc,
    output logic                strobe
);
    import i2c_tmr_pkg::*;

    localparam int CNT_W = BAUD_W + 1;
    localparam int CMP_W = (SETUP_W > CNT_W) ? SETUP_W : CNT_W;

    logic [CMP_W-1:0] want;
    logic [CMP_W-1:0] last;
    logic [CMP_W-1:0] offset;

    // Choose and clamp the strobe position within the low phase.
    always_comb begin
        want   = stretched ? CMP_W'(setup_cyc) : '0;
        last   = CMP_W'(low_len) - 1'b1;
        offset = (want > last) ? last : want;
        strobe = (ph == PH_LOW) && (CMP_W'(low_pos) == offset);
    end

endmodule

// File: rtl/i2c_scl_timer.sv
// Top of the SCL phase timer. Splits the baud word, resolves the rate,
// runs the phase sequencer and places the SDA strobe. The high-speed
// half of the baud word is accepted but unused.
module i2c_scl_timer #(
    parameter int BAUD_W  = 16,
    parameter int SETUP_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [2*BAUD_W-1:0] baud_word,
    input  logic [1:0]          speed,
    input  logic [SETUP_W-1:0]  setup_cyc,
    input  logic                scl_in,
    output logic                scl_pull_low,
    output logic                scl_fall,
    output logic                scl_rise,
    output logic                sda_strobe
);
    import i2c_tmr_pkg::*;

    logic [BAUD_W-1:0] unit;
    logic [BAUD_W:0]   low_len;
    logic [BAUD_W:0]   low_pos;
    logic              stretched;
    phase_t            ph;
    logic              unused_hs_half;

    // Upper half is reserved for the unsupported high-speed count.
    assign unused_hs_half = ^baud_word[2*BAUD_W-1:BAUD_W];

    i2c_tmr_rate #(.BAUD_W(BAUD_W), .LONG_MULT(2)) u_rate (
        .baud    (baud_word[BAUD_W-1:0]),
        .speed   (speed),
        .unit    (unit),
        .low_len (low_len)
    );

    i2c_tmr_seq #(.BAUD_W(BAUD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .scl_in    (scl_in),
        .unit      (unit),
        .low_len   (low_len),
        .ph        (ph),
        .low_pos   (low_pos),
        .stretched (stretched),
        .rise_p    (scl_rise),
        .fall_p    (scl_fall)
    );

    i2c_tmr_setup #(.BAUD_W(BAUD_W), .SETUP_W(SETUP_W)) u_setup (
        .ph        (ph),
        .low_pos   (low_pos),
        .low_len   (low_len),
        .stretched (stretched),
        .setup_cyc (setup_cyc),
        .strobe    (sda_strobe)
    );

    // Pull the line low only in the low phase.
    always_comb begin
        scl_pull_low = (ph == PH_LOW);
    end

endmodule

// File: rtl/i2c_scl_timer_chk.sv
// Property checker for the SCL phase timer, bound to the top module.
// Assumes scl_in low only while the line is pulled or held by a target.
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic scl_pull_low,
    input logic scl_fall,
    input logic scl_rise,
    input logic sda_strobe
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull_low && !scl_rise && !scl_fall && !sda_strobe)); // R2

    AST_FALL_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> scl_fall); // R3

    AST_FALL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> scl_pull_low); // R3

    AST_RISE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_pull_low) && $past(en)) |-> scl_rise); // R7

    AST_STRETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(rst_n) && !scl_pull_low && !scl_in) |=> !scl_pull_low); // R8

    AST_STROBE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_strobe |-> scl_pull_low); // R11

    AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_fall && scl_rise)); // R12

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise); // R12

endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .scl_in       (scl_in),
    .scl_pull_low (scl_pull_low),
    .scl_fall     (scl_fall),
    .scl_rise     (scl_rise),
    .sda_strobe   (sda_strobe)
);

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] baud_word = 32'd3;
    logic [1:0]  speed = 2'd0;
    logic [7:0]  setup_cyc = 8'd0;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        o_pull, o_fall, o_rise, o_strobe;

    int n_checks = 0;
    int n_fails = 0;
    int cyc = 0;
    int stretch_len = 0;
    int hold_left = 0;
    bit line_s = 1'b1;
    bit done = 1'b0;
    string cur_req = "R1";

    // Reference model state (countdown based).
    int m_ph = 0;      // 0 idle, 1 low, 2 high
    int m_pos = 0;     // cycles already spent in low
    int m_hi_left = 0; // high-sampled edges still needed
    bit m_str = 0;
    bit m_rise = 0;
    bit m_fall = 0;

    always #2 clk = ~clk;

    assign scl_in = !o_pull && !hold;

    i2c_scl_timer u_i2c_scl_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .baud_word    (baud_word),
        .speed        (speed),
        .setup_cyc    (setup_cyc),
        .scl_in       (scl_in),
        .scl_pull_low (o_pull),
        .scl_fall     (o_fall),
        .scl_rise     (o_rise),
        .sda_strobe   (o_strobe)
    );

    function automatic int f_unit();
        return (baud_word[15:0] == 16'd0) ? 1 : int'(baud_word[15:0]);
    endfunction

    function automatic int f_low_len();
        return (speed == 2'd1 || speed == 2'd2) ? 2 * f_unit() : f_unit();
    endfunction

    function automatic bit f_strobe();
        int off;
        off = m_str ? int'(setup_cyc) : 0;
        if (off > f_low_len() - 1) off = f_low_len() - 1;
        return (m_ph == 1) && (m_pos == off);
    endfunction

    // Reference model advance on each edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n || !en) begin
            m_ph = 0; m_pos = 0; m_str = 0; m_rise = 0; m_fall = 0;
        end else if (m_ph == 0) begin
            m_ph = 1; m_pos = 0; m_str = 0; m_fall = 1; m_rise = 0;
        end else if (m_ph == 1) begin
            m_fall = 0; m_rise = 0;
            if (m_pos + 1 == f_low_len()) begin
                m_ph = 2; m_hi_left = f_unit(); m_str = 0; m_rise = 1;
            end else begin
                m_pos++;
            end
        end else begin
            m_fall = 0; m_rise = 0;
            if (!line_s) m_str = 1;
            else begin
                m_hi_left--;
                if (m_hi_left == 0) begin
                    m_ph = 1; m_pos = 0; m_fall = 1;
                end
            end
        end
    end

    // Compare, drive the target hold, sample the line.
    always @(negedge clk) begin
        n_checks++;
        if (o_pull !== (m_ph == 1) || o_fall !== m_fall || o_rise !== m_rise
            || o_strobe !== f_strobe()) begin
            n_fails++;
            $display("FAIL %s cycle %0d: pull/fall/rise/strobe actual %b%b%b%b expected %b%b%b%b",
                     cur_req, cyc, o_pull, o_fall, o_rise, o_strobe,
                     (m_ph == 1), m_fall, m_rise, f_strobe());
        end
        if (o_rise && stretch_len > 0) hold_left = stretch_len;
        if (hold_left > 0) begin hold = 1'b1; hold_left--; end
        else hold = 1'b0;
        line_s = !o_pull && !hold;
    end

    task automatic run(input string req, input logic [1:0] spd, input logic [31:0] bw,
                       input logic [7:0] su, input int str_len, input int ncyc);
        @(negedge clk);
        cur_req = req;
        speed = spd; baud_word = bw; setup_cyc = su; stretch_len = str_len;
        @(negedge clk);
        en = 1'b1;
        repeat (ncyc) @(negedge clk);
        en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);            // R1 reset state compared each cycle
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run("R4", 2'd0, 32'd3, 8'd0, 0, 40);            // standard timing, R7 high phase
        run("R5", 2'd1, 32'd2, 8'd1, 3, 60);            // fast, stretch R8, setup R11
        run("R5", 2'd2, 32'd4, 8'd10, 2, 80);           // fast-plus, setup clamp R11
        run("R11", 2'd1, 32'd5, 8'd3, 4, 90);           // setup within low phase
        run("R6", 2'd3, 32'd3, 8'd0, 0, 40);            // high-speed code falls back
        run("R9", 2'd0, 32'd0, 8'd0, 0, 20);            // zero baud acts as one
        run("R9", 2'd1, 32'd0, 8'd5, 1, 30);            // zero baud, fast, stretched
        run("R10", 2'd0, 32'hFFFF_0002, 8'd0, 0, 30);   // upper half ignored
        run("R10", 2'd1, 32'h1234_0003, 8'd2, 2, 50);
        run("R2", 2'd0, 32'd6, 8'd0, 0, 5);             // disable mid low phase
        run("R2", 2'd0, 32'd3, 8'd0, 5, 6);             // disable mid stretch
        run("R8", 2'd0, 32'd1, 8'd0, 7, 60);            // long stretch, R12 ticks
        cur_req = "R1";
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule